// File: doc/BRIEF.md
# USB Low/Full-Speed Packet Line Serializer

This block turns a packet handed over one byte at a time into the two-wire line states of a low- or full-speed USB transmitter. The byte source presents a packet identifier first, flagged as the start of the packet, and then any payload and check bytes, with the last byte flagged. CRC values are computed elsewhere and arrive as ordinary bytes. The serializer puts the synchronisation pattern on the line ahead of the first byte. It sends every byte least significant bit first, adds stuff bits so that the line keeps changing, and NRZI-encodes the stream. It closes the packet with a single-ended zero, one idle bit, and release of the output enable.

Bit timing comes from a one-cycle strobe input. Every line change happens on a clock edge at which the strobe is high. The byte handshake is ready/valid. Ready is raised only on the strobe cycle in which the first bit of the offered byte goes onto the line. This leaves the whole bit period before it for the source to prepare the byte. A parameter selects the line polarity of the idle state: D+ high for full speed, D- high for low speed.

Top module: `usb_pkt_serializer`

## Requirements
- R1: After reset, and whenever no packet is in progress, `line_oe` is 0 and the line shows the idle J state (full speed: `line_dp`=1, `line_dm`=0).
- R2: On a strobe at which `byte_valid` and `byte_first` are both high while idle, `line_oe` rises and the unencoded bits 0,0,0,0,0,0,0,1 go out on eight consecutive strobes, starting from J. On the line this gives K,J,K,J,K,J,K,K, where K is `line_dp`=0 and `line_dm`=1.
- R3: The bytes follow the synchronisation bits with no gap, least significant bit first, NRZI encoded. A 0 bit inverts the line level and a 1 bit keeps it. While data is sent, `line_dp` and `line_dm` are complements.
- R4: After six consecutive 1 bits, an extra 0 bit goes out before the next information bit. The run count includes the final 1 of the synchronisation pattern and continues across byte borders.
- R5: If the final data bit completes a run of six 1 bits, the stuff bit is still sent before the end of packet.
- R6: After the last bit, both lines are driven low for two strobes, then J for one strobe, and `line_oe` falls on the next strobe.
- R7: `byte_ready` is high only on a strobe cycle that puts bit 0 of the offered byte on the line. It is never high on a synchronisation, stuff or end-of-packet bit. A byte is taken when `byte_ready` and `byte_valid` are both high at a clock edge.
- R8: If no byte is valid at a byte boundary of an unfinished packet, the packet ends there with the same end-of-packet sequence as R6.
- R9: While idle, a valid byte without `byte_first` is accepted and discarded. The line stays idle.
- R10: Line outputs change only on clock edges at which `bit_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle pulse once per bit period |
| byte_data | input | DATA_W | Byte offered by the source |
| byte_valid | input | 1 | Source holds a byte |
| byte_first | input | 1 | Offered byte is the packet identifier opening a packet |
| byte_last | input | 1 | Offered byte closes the packet |
| byte_ready | output | 1 | Offered byte is taken at this edge |
| line_dp | output | 1 | D+ line level |
| line_dm | output | 1 | D- line level |
| line_oe | output | 1 | Line driver enable |

## Verification
The hardest case to reach is a stuff bit that falls exactly at a border. One border is just before the end of packet. Another is right after the synchronisation pattern, where the pattern's trailing 1 already counts toward the run. A third is a byte boundary, where the stuff bit must also delay `byte_ready` by one strobe. The stimulus picks byte values whose runs of 1 bits, sent least significant bit first, end exactly at those points. A scoreboard model computes the expected line symbols and the strobe offset of every byte handshake from the byte list. The same packets are also cut short by withholding the next byte, which exercises the underrun end.

// File: rtl/usb_ser_pkg.sv
package usb_ser_pkg;

   // Number of synchronisation bits and their unencoded values, LSB sent first
   localparam int SYNC_W = 8;
   localparam logic [SYNC_W-1:0] SYNC_PAT = {1'b1, {(SYNC_W-1){1'b0}}};

   // Symbol handed from the sequencer to the line stage for one bit period
   typedef enum logic [1:0] {
      SYM_OFF  = 2'd0,
      SYM_DATA = 2'd1,
      SYM_SE0  = 2'd2,
      SYM_J    = 2'd3
   } sym_kind_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SYNC = 3'd1,
      ST_DATA = 3'd2,
      ST_EOP  = 3'd3,
      ST_TAIL = 3'd4
   } seq_state_t;

endpackage

// File: rtl/usb_ser_stuffer.sv
module usb_ser_stuffer
   import usb_ser_pkg::*;
#(
   parameter int RUN_LIMIT = 6
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_stb,
   input  sym_kind_t sym_kind,
   input  logic      sym_bit,
   output logic      stuff_due
);

   localparam int RUN_W = $clog2(RUN_LIMIT + 1);
   localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LIMIT);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_stb) begin
         if (sym_kind == SYM_DATA && sym_bit) run_q <= run_q + 1'b1;
         else                                 run_q <= '0;
      end
   end

   assign stuff_due = (run_q == RUN_TOP);

   // R4
   run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_TOP);

   // R4
   stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && stuff_due) |-> (sym_kind == SYM_DATA && !sym_bit));

endmodule

// File: rtl/usb_ser_sequencer.sv
module usb_ser_sequencer
   import usb_ser_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SE0_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              byte_valid,
   input  logic              byte_first,
   input  logic              byte_last,
   input  logic              stuff_due,
   output logic              byte_ready,
   output sym_kind_t         sym_kind,
   output logic              sym_bit
);

   localparam int BIT_W  = $clog2(DATA_W);
   localparam int SYNC_IW = $clog2(SYNC_W);
   localparam int SE0_W  = $clog2(SE0_LEN + 1);
   localparam logic [BIT_W-1:0]   BIT_LAST  = BIT_W'(DATA_W - 1);
   localparam logic [SYNC_IW-1:0] SYNC_LAST = SYNC_IW'(SYNC_W - 1);
   localparam logic [SE0_W-1:0]   SE0_TOP   = SE0_W'(SE0_LEN);

   initial begin : param_chk
      assert (DATA_W >= 2 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("DATA_W must be a power of two");
      assert (SE0_LEN >= 1) else $error("SE0_LEN must be at least 1");
   end

   seq_state_t          state_q, state_d;
   logic [SYNC_IW-1:0]  sync_idx_q, sync_idx_d;
   logic [BIT_W-1:0]    bit_idx_q, bit_idx_d;
   logic [SE0_W-1:0]    se0_cnt_q, se0_cnt_d;
   logic [DATA_W-1:0]   shreg_q, shreg_d;
   logic                done_q, done_d;

   always_comb begin
      state_d    = state_q;
      sync_idx_d = sync_idx_q;
      bit_idx_d  = bit_idx_q;
      se0_cnt_d  = se0_cnt_q;
      shreg_d    = shreg_q;
      done_d     = done_q;
      byte_ready = 1'b0;
      sym_kind   = SYM_OFF;
      sym_bit    = 1'b1;
      unique case (state_q)
         ST_IDLE: begin
            if (byte_valid && byte_first) begin
               sym_kind = SYM_DATA;
               sym_bit  = SYNC_PAT[0];
               if (bit_stb) begin
                  state_d    = ST_SYNC;
                  sync_idx_d = SYNC_IW'(1);
               end
            end else if (byte_valid) begin
               // stray byte outside a packet: swallow it
               byte_ready = bit_stb;
            end
         end
         ST_SYNC: begin
            sym_kind = SYM_DATA;
            sym_bit  = SYNC_PAT[sync_idx_q];
            if (bit_stb) begin
               if (sync_idx_q == SYNC_LAST) begin
                  state_d   = ST_DATA;
                  bit_idx_d = '0;
                  done_d    = 1'b0;
               end else begin
                  sync_idx_d = sync_idx_q + 1'b1;
               end
            end
         end
         ST_DATA: begin
            if (stuff_due) begin
               sym_kind = SYM_DATA;
               sym_bit  = 1'b0;
            end else if (bit_idx_q == '0) begin
               if (!done_q && byte_valid) begin
                  sym_kind   = SYM_DATA;
                  sym_bit    = byte_data[0];
                  byte_ready = bit_stb;
                  if (bit_stb) begin
                     shreg_d   = byte_data;
                     bit_idx_d = BIT_W'(1);
                     done_d    = byte_last;
                  end
               end else begin
                  sym_kind = SYM_SE0;
                  if (bit_stb) begin
                     state_d   = ST_EOP;
                     se0_cnt_d = SE0_W'(1);
                  end
               end
            end else begin
               sym_kind = SYM_DATA;
               sym_bit  = shreg_q[bit_idx_q];
               if (bit_stb) begin
                  bit_idx_d = (bit_idx_q == BIT_LAST) ? '0 : bit_idx_q + 1'b1;
               end
            end
         end
         ST_EOP: begin
            if (se0_cnt_q < SE0_TOP) begin
               sym_kind = SYM_SE0;
               if (bit_stb) se0_cnt_d = se0_cnt_q + 1'b1;
            end else begin
               sym_kind = SYM_J;
               if (bit_stb) state_d = ST_TAIL;
            end
         end
         ST_TAIL: begin
            sym_kind = SYM_OFF;
            if (bit_stb) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         sync_idx_q <= '0;
         bit_idx_q  <= '0;
         se0_cnt_q  <= '0;
         shreg_q    <= '0;
         done_q     <= 1'b0;
      end else begin
         state_q    <= state_d;
         sync_idx_q <= sync_idx_d;
         bit_idx_q  <= bit_idx_d;
         se0_cnt_q  <= se0_cnt_d;
         shreg_q    <= shreg_d;
         done_q     <= done_d;
      end
   end

   // R7
   ready_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ready && byte_valid && byte_first == 1'b0 && state_q == ST_DATA)
         |-> (sym_kind == SYM_DATA && sym_bit == byte_data[0] && !stuff_due));

   // R7
   ready_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready |-> bit_stb);

endmodule

// File: rtl/usb_ser_line.sv
module usb_ser_line
   import usb_ser_pkg::*;
#(
   parameter bit LOW_SPEED = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_stb,
   input  sym_kind_t sym_kind,
   input  logic      sym_bit,
   output logic      line_dp,
   output logic      line_dm,
   output logic      line_oe
);

   // lvl_q = 1 means the J state, 0 means K
   logic lvl_q, se0_q, oe_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b1;
         se0_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (bit_stb) begin
         unique case (sym_kind)
            SYM_DATA: begin
               lvl_q <= sym_bit ? lvl_q : ~lvl_q;
               se0_q <= 1'b0;
               oe_q  <= 1'b1;
            end
            SYM_SE0: begin
               lvl_q <= 1'b1;
               se0_q <= 1'b1;
               oe_q  <= 1'b1;
            end
            SYM_J: begin
               lvl_q <= 1'b1;
               se0_q <= 1'b0;
               oe_q  <= 1'b1;
            end
            default: begin
               lvl_q <= 1'b1;
               se0_q <= 1'b0;
               oe_q  <= 1'b0;
            end
         endcase
      end
   end

   generate
      if (LOW_SPEED) begin : g_low
         assign line_dp = !se0_q && !lvl_q;
         assign line_dm = !se0_q &&  lvl_q;
      end else begin : g_full
         assign line_dp = !se0_q &&  lvl_q;
         assign line_dm = !se0_q && !lvl_q;
      end
   endgenerate

   assign line_oe = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R10
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !$past(bit_stb)) |-> $stable({lvl_q, se0_q, oe_q}));

   // R6
   release_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $fell(oe_q)) |-> ($past(lvl_q) && !$past(se0_q)));

   // R3
   data_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $past(bit_stb && sym_kind == SYM_DATA && !sym_bit))
         |-> (lvl_q != $past(lvl_q)));

endmodule

// File: rtl/usb_pkt_serializer.sv
module usb_pkt_serializer
   import usb_ser_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int RUN_LIMIT = 6,
   parameter int SE0_LEN   = 2,
   parameter bit LOW_SPEED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              byte_valid,
   input  logic              byte_first,
   input  logic              byte_last,
   output logic              byte_ready,
   output logic              line_dp,
   output logic              line_dm,
   output logic              line_oe
);

   initial begin : param_chk
      assert (RUN_LIMIT >= 1) else $error("RUN_LIMIT must be at least 1");
   end

   sym_kind_t sym_kind;
   logic      sym_bit;
   logic      stuff_due;

   usb_ser_sequencer #(
      .DATA_W  (DATA_W),
      .SE0_LEN (SE0_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bit_stb),
      .byte_data  (byte_data),
      .byte_valid (byte_valid),
      .byte_first (byte_first),
      .byte_last  (byte_last),
      .stuff_due  (stuff_due),
      .byte_ready (byte_ready),
      .sym_kind   (sym_kind),
      .sym_bit    (sym_bit)
   );

   usb_ser_stuffer #(
      .RUN_LIMIT (RUN_LIMIT)
   ) u_stuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .sym_kind  (sym_kind),
      .sym_bit   (sym_bit),
      .stuff_due (stuff_due)
   );

   usb_ser_line #(
      .LOW_SPEED (LOW_SPEED)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_stb  (bit_stb),
      .sym_kind (sym_kind),
      .sym_bit  (sym_bit),
      .line_dp  (line_dp),
      .line_dm  (line_dm),
      .line_oe  (line_oe)
   );

endmodule

// File: tb/tb_usb_pkt_serializer.sv
module tb_usb_pkt_serializer;

   localparam int CLK_PERIOD = 10;
   localparam int STB_DIV    = 4;

   logic       clk;
   logic       rst_n;
   logic       bit_stb;
   logic [7:0] byte_data;
   logic       byte_valid;
   logic       byte_first;
   logic       byte_last;
   logic       byte_ready;
   logic       line_dp;
   logic       line_dm;
   logic       line_oe;

   usb_pkt_serializer dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bit_stb),
      .byte_data  (byte_data),
      .byte_valid (byte_valid),
      .byte_first (byte_first),
      .byte_last  (byte_last),
      .byte_ready (byte_ready),
      .line_dp    (line_dp),
      .line_dm    (line_dm),
      .line_oe    (line_oe)
   );

   // {oe, dp, dm}
   localparam logic [2:0] L_IDLE = 3'b010;
   localparam logic [2:0] L_SE0  = 3'b100;
   localparam logic [2:0] L_J    = 3'b110;

   int         n_vec  = 0;
   int         n_fail = 0;
   string      cur_tag = "R1";
   logic [2:0] exp_q[$];
   int         off_q[$];
   logic [7:0] pkt_q[$];
   logic       m_lvl;
   int         m_run;
   int         m_pos;
   bit         in_pkt = 1'b0;
   bit         mon_en = 1'b0;
   int         start_idx = 0;
   int         stb_n;
   logic       stb_done;
   int         div;
   logic [2:0] prev_line;

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div      <= 0;
         bit_stb  <= 1'b0;
         stb_done <= 1'b0;
         stb_n    <= 0;
      end else begin
         div      <= (div == STB_DIV - 1) ? 0 : div + 1;
         bit_stb  <= (div == STB_DIV - 1);
         stb_done <= bit_stb;
         stb_n    <= stb_n + (bit_stb ? 1 : 0);
      end
   end

   // ---------------- expectation model ----------------
   task automatic emit_bit(input logic v);
      if (!v) m_lvl = ~m_lvl;
      exp_q.push_back({1'b1, m_lvl, ~m_lvl});
      m_pos++;
      m_run = v ? m_run + 1 : 0;
      if (m_run == 6) begin            // R4 stuff zero
         m_lvl = ~m_lvl;
         exp_q.push_back({1'b1, m_lvl, ~m_lvl});
         m_pos++;
         m_run = 0;
      end
   endtask

   task automatic build_expect();
      m_lvl = 1'b1;
      m_run = 0;
      m_pos = 0;
      off_q.delete();
      for (int i = 0; i < 8; i++) emit_bit(i == 7);
      foreach (pkt_q[k]) begin
         off_q.push_back(m_pos);
         for (int b = 0; b < 8; b++) emit_bit(pkt_q[k][b]);
      end
      exp_q.push_back(L_SE0);
      exp_q.push_back(L_SE0);
      exp_q.push_back(L_J);
      exp_q.push_back(L_IDLE);
   endtask

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      logic [2:0] got;
      logic [2:0] e;
      got = {line_oe, line_dp, line_dm};
      if (rst_n && mon_en) begin
         if (stb_done) begin
            if (!in_pkt && got[2]) begin
               in_pkt    = 1'b1;
               start_idx = stb_n - 1;
            end
            if (in_pkt) begin
               n_vec++;
               if (exp_q.size() == 0) begin
                  n_fail++;
                  $display("FAIL %s: line %b driven with no symbol expected (expected %b)",
                           cur_tag, got, L_IDLE);
                  in_pkt = 1'b0;
               end else begin
                  e = exp_q.pop_front();
                  if (got !== e) begin
                     n_fail++;
                     $display("FAIL %s: line symbol got %b expected %b", cur_tag, got, e);
                  end
                  if (!e[2]) in_pkt = 1'b0;
               end
            end else begin
               // R1 idle line between packets
               n_vec++;
               if (got !== L_IDLE) begin
                  n_fail++;
                  $display("FAIL R1/%s: idle line got %b expected %b", cur_tag, got, L_IDLE);
               end
            end
         end else begin
            // R10 no change without a strobe
            n_vec++;
            if (got !== prev_line) begin
               n_fail++;
               $display("FAIL R10: line changed off-strobe got %b expected %b", got, prev_line);
            end
         end
      end
      prev_line = got;
   end

   // ---------------- driver ----------------
   task automatic send_byte(input logic [7:0] d, input bit first, input bit last,
                            input bit chk_off);
      int exp_off;
      @(negedge clk);
      byte_data  = d;
      byte_valid = 1'b1;
      byte_first = first;
      byte_last  = last;
      while (1) begin
         #1;
         if (byte_ready) break;
         @(negedge clk);
      end
      if (chk_off) begin
         // R7 handshake lands on the strobe carrying bit 0
         exp_off = (off_q.size() != 0) ? off_q.pop_front() : -1;
         n_vec++;
         if (stb_n - start_idx != exp_off) begin
            n_fail++;
            $display("FAIL R7: byte %h taken at strobe offset %0d expected %0d",
                     d, stb_n - start_idx, exp_off);
         end
      end
      @(posedge clk);
      #1;
      byte_valid = 1'b0;
      byte_first = 1'b0;
      byte_last  = 1'b0;
   endtask

   task automatic run_packet(input string tag, input bit underrun);
      int n;
      cur_tag = tag;
      build_expect();
      n = pkt_q.size();
      for (int i = 0; i < n; i++)
         send_byte(pkt_q[i], i == 0, (i == n - 1) && !underrun, 1'b1);
      while (exp_q.size() != 0 || in_pkt) @(negedge clk);
      repeat (3 * STB_DIV) @(negedge clk);
      pkt_q.delete();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish (expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin : main
      rst_n      = 1'b0;
      byte_data  = 8'h00;
      byte_valid = 1'b0;
      byte_first = 1'b0;
      byte_last  = 1'b0;
      repeat (4) @(negedge clk);
      // R1 reset state
      n_vec++;
      if ({line_oe, line_dp, line_dm, byte_ready} !== {L_IDLE, 1'b0}) begin
         n_fail++;
         $display("FAIL R1: reset outputs got %b expected %b",
                  {line_oe, line_dp, line_dm, byte_ready}, {L_IDLE, 1'b0});
      end
      rst_n = 1'b1;
      @(negedge clk);
      mon_en = 1'b1;
      repeat (4 * STB_DIV) @(negedge clk);

      // R2 R6: handshake-only packet, sync then pid then end of packet
      pkt_q.push_back(8'hD2);
      run_packet("R2 R6", 1'b0);

      // R3: mixed data packet
      pkt_q.push_back(8'hC3);
      pkt_q.push_back(8'h01);
      pkt_q.push_back(8'h80);
      pkt_q.push_back(8'h5A);
      pkt_q.push_back(8'h12);
      pkt_q.push_back(8'h34);
      run_packet("R3", 1'b0);

      // R4: long runs of ones across byte borders
      pkt_q.push_back(8'h4B);
      pkt_q.push_back(8'hFF);
      pkt_q.push_back(8'hFF);
      pkt_q.push_back(8'hFF);
      pkt_q.push_back(8'h00);
      run_packet("R4", 1'b0);

      // R4: sync trailing one plus five ones in the first byte
      pkt_q.push_back(8'h1F);
      pkt_q.push_back(8'hF0);
      run_packet("R4", 1'b0);

      // R5: final byte ends with six ones
      pkt_q.push_back(8'hC3);
      pkt_q.push_back(8'hFC);
      run_packet("R5", 1'b0);

      // R8: source stops without marking a last byte
      pkt_q.push_back(8'h69);
      pkt_q.push_back(8'h00);
      run_packet("R8", 1'b1);

      // R9: stray byte with no start flag while idle
      cur_tag = "R9";
      send_byte(8'hA5, 1'b0, 1'b0, 1'b0);
      repeat (12 * STB_DIV) @(negedge clk);

      // packet after the stray byte still framed correctly
      pkt_q.push_back(8'h5A);
      pkt_q.push_back(8'h7E);
      run_packet("R9", 1'b0);

      n_vec++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R6: %0d symbols never seen (expected 0)", exp_q.size());
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule